// File: doc/BRIEF.md
# Modem Ring and Status Conditioner

This block sits between a modem chipset and the card-side host interface. It takes the modem's ring line, which toggles at roughly 20 Hz while the telephone line rings and rests low otherwise, and produces clean ring indications for the host. A retriggerable stretcher turns the toggling into a steady "ringing" level. Two ring outputs of opposite sense apply different power-down rules. A status-changed output selects either the stretched ring level or a modem-changed status bit. The block also gates the speaker path and drives the modem power-down pins.

Power management is held in two small state machines. The wake machine (`PW_DOWN`, `PW_WAKE`, `PW_ACTIVE`) keeps ring output A dark while the modem is powered down or the function is disabled. It also keeps A dark for a settling window after power returns. Its transitions are: `PW_DOWN`→`PW_WAKE` when power-down clears; `PW_WAKE`→`PW_ACTIVE` when the window expires; and `PW_WAKE`/`PW_ACTIVE`→`PW_DOWN` whenever power-down returns. The ring-B machine (`RB_FOLLOW`, `RB_LOW`, `RB_HIGH`, `RB_PARK`) marks every power-down transition with a rising edge. Its transitions are: any state→`RB_LOW` on a change of the power-down condition; `RB_LOW`→`RB_PARK` when the low phase ends while powered down; `RB_LOW`→`RB_HIGH` when the low phase ends while powered up; and `RB_HIGH`→`RB_FOLLOW` when the high phase ends. All windows are given in clock cycles. The defaults (100 ms stretch, 12 ms wake delay, 100 us pulse phases) assume a 20 MHz clock.

Top module: `mdm_ring_cond`

## Requirements
- R1: The ring input passes through a two-flop synchronizer. Every ring-derived output uses the synchronized value, which lags `ring_in` by two clock edges.
- R2: The stretched ring level goes active on the edge after a change of the synchronized ring is seen. Each further change retriggers it. It stays active for exactly `STRETCH_CYC` cycles after the last change, then drops.
- R3: `sts_chg_o` equals the stretched ring level when `ring_sel` is 1 and equals `modem_chg` when `ring_sel` is 0.
- R4: The power-down condition is `pwrdn_bit` = 1 or `func_en` = 0. After any clock edge that samples this condition true, the wake machine is in `PW_DOWN` and `ring_a_o` is 0.
- R5: When the power-down condition clears, `ring_a_o` stays 0 for `WAKE_CYC` more cycles in `PW_WAKE`. It is released on the `WAKE_CYC`+1-th consecutive edge that samples the condition false. Reset leaves the machine in `PW_DOWN`.
- R6: In `PW_ACTIVE`, `ring_a_o` is 1 while the stretched ring level is inactive, and the inverse of the synchronized ring while it is active.
- R7: In `RB_FOLLOW`, `ring_b_o` equals the synchronized ring.
- R8: After each edge that sees the power-down condition differ from its value at the previous edge (taken as 1 at reset), `ring_b_o` is 0 for `PULSE_CYC` cycles. It then rises. When entering power-down it stays 1 (`RB_PARK`). When leaving power-down it stays 1 for `PULSE_CYC` cycles before returning to following.
- R9: A new power-down transition during either pulse phase restarts the low phase at once, using the new direction.
- R10: `spk_oe_o` equals `audio_en`. `spk_o` equals `spk_in` while `audio_en` is 1 and is 0 otherwise.
- R11: `mdm_pwdn_n_o` is 0 and `mdm_idle_o` is 1 exactly while the power-down condition holds; otherwise `mdm_pwdn_n_o` is 1 and `mdm_idle_o` is 0.
- R12: While `rst_n` is low, `ring_a_o` is 0 and `ring_b_o` is 1 (`RB_PARK`), and the stretched ring level is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_in | input | 1 | Ring line from the modem, asynchronous |
| pwrdn_bit | input | 1 | Modem power-down control bit |
| func_en | input | 1 | Modem function enabled |
| ring_sel | input | 1 | 1: status shows stretched ring; 0: modem-changed bit |
| modem_chg | input | 1 | Modem-changed status bit |
| audio_en | input | 1 | Speaker path enable |
| spk_in | input | 1 | Digitized speaker signal from the modem |
| ring_a_o | output | 1 | Ring output A (inverted sense, dark in power-down) |
| ring_b_o | output | 1 | Ring output B (follows ring, marks power transitions) |
| sts_chg_o | output | 1 | Status-changed output |
| spk_o | output | 1 | Speaker output data |
| spk_oe_o | output | 1 | Speaker output drive enable (0 = high impedance) |
| mdm_pwdn_n_o | output | 1 | Modem power-down, active low |
| mdm_idle_o | output | 1 | Modem power-down, active high |

## Verification
The bench builds the block with `STRETCH_CYC` = 20, `WAKE_CYC` = 30 and `PULSE_CYC` = 3. At these values the whole stretch window, its expiry and its retrigger fit inside a few dozen cycles. The same holds for the complete wake delay and the two-phase ring-B pulse. Ring toggle periods are chosen both shorter and longer than the stretch window, so the level is seen both held and dropping between edges. Power-down is toggled faster than a pulse phase so that the restart of R9 occurs repeatedly.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

    // Wake sequencing for ring output A
    typedef enum logic [1:0] {
        PW_DOWN   = 2'd0,
        PW_WAKE   = 2'd1,
        PW_ACTIVE = 2'd2
    } pwr_state_t;

    // Ring output B sequencing
    typedef enum logic [1:0] {
        RB_FOLLOW = 2'd0,
        RB_LOW    = 2'd1,
        RB_HIGH   = 2'd2,
        RB_PARK   = 2'd3
    } rb_state_t;

endpackage

// File: rtl/mrc_sync.sv
module mrc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic dchg
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] shreg;
    logic          prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[LAST-1:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= shreg[LAST];
    end

    assign dout = shreg[LAST];
    assign dchg = shreg[LAST] ^ prev_q;

endmodule

// File: rtl/mrc_stretch.sv
module mrc_stretch #(
    parameter int STRETCH_CYC = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(STRETCH_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               remain_q <= '0;
        else if (trig)            remain_q <= LOAD;
        else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
    end

    assign active = (remain_q != '0);

endmodule

// File: rtl/mrc_wake_fsm.sv
module mrc_wake_fsm
    import mrc_pkg::*;
#(
    parameter int WAKE_CYC = 240_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic down,
    input  logic ring_s,
    input  logic ring_active,
    output logic ring_a
);
    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam logic [WW-1:0] WLOAD = WW'(WAKE_CYC - 1);

    pwr_state_t    state_q, state_d;
    logic [WW-1:0] wcnt_q;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_DOWN:   if (!down) state_d = PW_WAKE;
            PW_WAKE:   if (down) state_d = PW_DOWN;
                       else if (wcnt_q == '0) state_d = PW_ACTIVE;
            PW_ACTIVE: if (down) state_d = PW_DOWN;
            default:   state_d = PW_DOWN;
        endcase
    end

    // state register and settling counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PW_DOWN;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PW_DOWN && state_d == PW_WAKE)
                wcnt_q <= WLOAD;
            else if (state_q == PW_WAKE && wcnt_q != '0)
                wcnt_q <= wcnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PW_ACTIVE: ring_a = ring_active ? ~ring_s : 1'b1;
            PW_DOWN,
            PW_WAKE:   ring_a = 1'b0;
            default:   ring_a = 1'b0;
        endcase
    end

endmodule

// File: rtl/mrc_ringb_fsm.sv
module mrc_ringb_fsm
    import mrc_pkg::*;
#(
    parameter int PULSE_CYC = 2_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic down,
    input  logic ring_s,
    output logic ring_b
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYC - 1);

    rb_state_t     state_q, state_d;
    logic [PW-1:0] pcnt_q;
    logic          down_q;
    logic          flip;

    assign flip = down ^ down_q;

    // next-state
    always_comb begin
        state_d = state_q;
        if (flip) begin
            state_d = RB_LOW;
        end else begin
            unique case (state_q)
                RB_LOW:    if (pcnt_q == '0) state_d = down ? RB_PARK : RB_HIGH;
                RB_HIGH:   if (pcnt_q == '0) state_d = RB_FOLLOW;
                RB_FOLLOW: state_d = RB_FOLLOW;
                RB_PARK:   state_d = RB_PARK;
                default:   state_d = RB_PARK;
            endcase
        end
    end

    // state register, phase counter, previous condition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RB_PARK;
            pcnt_q  <= '0;
            down_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            down_q  <= down;
            if (flip || (state_q == RB_LOW && pcnt_q == '0))
                pcnt_q <= PLOAD;
            else if (pcnt_q != '0)
                pcnt_q <= pcnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            RB_FOLLOW: ring_b = ring_s;
            RB_LOW:    ring_b = 1'b0;
            RB_HIGH,
            RB_PARK:   ring_b = 1'b1;
            default:   ring_b = 1'b1;
        endcase
    end

endmodule

// File: rtl/mdm_ring_cond.sv
module mdm_ring_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int STRETCH_CYC = 2_000_000,
    parameter int WAKE_CYC    = 240_000,
    parameter int PULSE_CYC   = 2_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_in,
    input  logic pwrdn_bit,
    input  logic func_en,
    input  logic ring_sel,
    input  logic modem_chg,
    input  logic audio_en,
    input  logic spk_in,
    output logic ring_a_o,
    output logic ring_b_o,
    output logic sts_chg_o,
    output logic spk_o,
    output logic spk_oe_o,
    output logic mdm_pwdn_n_o,
    output logic mdm_idle_o
);
    logic ring_s;
    logic ring_edge;
    logic ring_active;
    logic down;

    assign down = pwrdn_bit | ~func_en;

    mrc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ring_in),
        .dout (ring_s),
        .dchg (ring_edge)
    );

    mrc_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_str (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (ring_edge),
        .active(ring_active)
    );

    mrc_wake_fsm #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .down       (down),
        .ring_s     (ring_s),
        .ring_active(ring_active),
        .ring_a     (ring_a_o)
    );

    mrc_ringb_fsm #(.PULSE_CYC(PULSE_CYC)) u_rb (
        .clk   (clk),
        .rst_n (rst_n),
        .down  (down),
        .ring_s(ring_s),
        .ring_b(ring_b_o)
    );

    always_comb begin
        sts_chg_o    = ring_sel ? ring_active : modem_chg;
        spk_oe_o     = audio_en;
        spk_o        = audio_en & spk_in;
        mdm_pwdn_n_o = ~down;
        mdm_idle_o   = down;
    end

endmodule

// File: rtl/mdm_ring_cond_chk.sv
module mdm_ring_cond_chk #(
    parameter int STRETCH_CYC = 2_000_000
) (
    input logic clk,
    input logic rst_n,
    input logic pwrdn_bit,
    input logic func_en,
    input logic ring_sel,
    input logic ring_edge,
    input logic ring_a_o,
    input logic sts_chg_o
);
    localparam int QW = $clog2(STRETCH_CYC + 1);
    localparam logic [QW-1:0] QMAX = QW'(STRETCH_CYC);

    logic          cond_down;
    logic [QW-1:0] quiet_q;
    logic          seen_q;

    assign cond_down = pwrdn_bit | ~func_en;

    // cycles since the last synchronized ring change, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quiet_q <= '0;
            seen_q  <= 1'b0;
        end else if (ring_edge) begin
            quiet_q <= '0;
            seen_q  <= 1'b1;
        end else if (quiet_q != QMAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    a_r4_ring_a_dark: assert property (@(posedge clk) disable iff (!rst_n)
        cond_down |=> !ring_a_o);

    a_r5_wake_holds_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond_down && $past(cond_down)) |=> !ring_a_o);

    a_r2_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_sel && seen_q && quiet_q < QMAX) |-> sts_chg_o);

    a_r2_stretch_expires: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_sel && quiet_q == QMAX) |-> !sts_chg_o);

endmodule

bind mdm_ring_cond mdm_ring_cond_chk #(.STRETCH_CYC(STRETCH_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwrdn_bit(pwrdn_bit),
    .func_en  (func_en),
    .ring_sel (ring_sel),
    .ring_edge(ring_edge),
    .ring_a_o (ring_a_o),
    .sts_chg_o(sts_chg_o)
);

// File: tb/sim_mdm_ring_cond.sv
module sim_mdm_ring_cond;

    localparam int STR = 20;
    localparam int WK  = 30;
    localparam int PL  = 3;
    localparam int BIG = 1_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_in = 1'b0, pwrdn_bit = 1'b0, func_en = 1'b0, ring_sel = 1'b1;
    logic modem_chg = 1'b0, audio_en = 1'b0, spk_in = 1'b0;
    logic ring_a_o, ring_b_o, sts_chg_o, spk_o, spk_oe_o, mdm_pwdn_n_o, mdm_idle_o;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    mdm_ring_cond #(.SYNC_STAGES(2), .STRETCH_CYC(STR), .WAKE_CYC(WK), .PULSE_CYC(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .ring_in(ring_in), .pwrdn_bit(pwrdn_bit),
        .func_en(func_en), .ring_sel(ring_sel), .modem_chg(modem_chg),
        .audio_en(audio_en), .spk_in(spk_in), .ring_a_o(ring_a_o),
        .ring_b_o(ring_b_o), .sts_chg_o(sts_chg_o), .spk_o(spk_o),
        .spk_oe_o(spk_oe_o), .mdm_pwdn_n_o(mdm_pwdn_n_o), .mdm_idle_o(mdm_idle_o)
    );

    // ---------------- behavioural reference ----------------
    bit h_a, h_b, h_c;      // ring_in samples, newest first
    int since_chg;          // edges since a synchronized change was seen
    int up_run;             // consecutive edges sampling power-down false
    bit prev_down;
    int since_flip;
    bit flip_dir;

    always @(posedge clk) begin
        bit cur_down;
        cur_down = pwrdn_bit | ~func_en;
        if (!rst_n) begin
            h_a = 0; h_b = 0; h_c = 0;
            since_chg = BIG; up_run = 0;
            prev_down = 1; since_flip = BIG; flip_dir = 1;
        end else begin
            if (h_b != h_c) since_chg = 0;
            else if (since_chg < BIG) since_chg++;
            h_c = h_b; h_b = h_a; h_a = ring_in;
            if (cur_down) up_run = 0;
            else if (up_run < BIG) up_run++;
            if (cur_down != prev_down) begin
                since_flip = 0; flip_dir = cur_down;
            end else if (since_flip < BIG) since_flip++;
            prev_down = cur_down;
        end
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        bit active, dn, ea, eb, es;
        string ra, rb, rs;
        active = since_chg < STR;
        dn = pwrdn_bit | ~func_en;
        if (!rst_n) begin
            chk("R12", "ring_a in reset", ring_a_o, 1'b0);
            chk("R12", "ring_b in reset", ring_b_o, 1'b1);
            chk("R12", "status in reset", sts_chg_o, ring_sel ? 1'b0 : modem_chg);
            return;
        end
        // ring A
        if (up_run == 0)       begin ea = 0; ra = "R4"; end
        else if (up_run <= WK) begin ea = 0; ra = "R5"; end
        else begin ea = active ? ~h_b : 1'b1; ra = "R6 R1"; end
        chk(ra, "ring_a", ring_a_o, ea);
        // ring B
        if (since_flip < PL)                 begin eb = 0; rb = "R8 R9"; end
        else if (since_flip < 2*PL || flip_dir) begin eb = 1; rb = "R8"; end
        else begin eb = h_b; rb = "R7 R1"; end
        chk(rb, "ring_b", ring_b_o, eb);
        // status
        if (ring_sel) begin es = active; rs = "R2 R3"; end
        else          begin es = modem_chg; rs = "R3"; end
        chk(rs, "status", sts_chg_o, es);
        chk("R10", "spk_oe", spk_oe_o, audio_en);
        chk("R10", "spk", spk_o, audio_en ? spk_in : 1'b0);
        chk("R11", "pwdn_n", mdm_pwdn_n_o, ~dn);
        chk("R11", "idle", mdm_idle_o, dn);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic ring_for(input int half, input int n);
        for (int i = 0; i < n; i++) begin
            if (i % half == 0) ring_in = ~ring_in;
            step(1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            finish_run();
        end
    end

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        // R12: reset state
        step(4);
        @(negedge clk);
        rst_n = 1'b1; func_en = 1'b1; pwrdn_bit = 1'b0;
        // R5 wake delay, R8 exit pulse, R6 idle high
        step(50);
        // R6 R7 R2: ringing shorter than the stretch window
        ring_for(6, 120);
        // R2: stretch expiry after ringing stops
        ring_in = 1'b0;
        step(40);
        // R3: status shows modem-changed bit
        ring_sel = 1'b0;
        for (int i = 0; i < 12; i++) begin modem_chg = i[1]; step(1); end
        ring_sel = 1'b1;
        // R10: speaker gate
        audio_en = 1'b1;
        for (int i = 0; i < 10; i++) begin spk_in = i[0]; step(1); end
        audio_en = 1'b0;
        for (int i = 0; i < 6; i++) begin spk_in = ~spk_in; step(1); end
        // R4 R8: power-down while ringing, then R5 wake during ringing
        pwrdn_bit = 1'b1;
        ring_for(5, 60);
        pwrdn_bit = 1'b0;
        ring_for(5, 60);
        // R4 R11: function disable
        func_en = 1'b0;
        step(15);
        func_en = 1'b1;
        step(45);
        // R9: transitions faster than a pulse phase
        for (int i = 0; i < 30; i++) begin
            if (i % 2 == 0) pwrdn_bit = ~pwrdn_bit;
            step(1);
        end
        pwrdn_bit = 1'b0;
        step(45);
        // R2: slow ringing with gaps longer than the stretch window
        ring_for(25, 150);
        // mixed pseudo-random traffic
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'd0) ring_in = ~ring_in;
            if (lfsr[9:4] == 6'd0) pwrdn_bit = ~pwrdn_bit;
            if (lfsr[15:10] == 6'd1) func_en = ~func_en;
            if (lfsr[7:2] == 6'd5) ring_sel = ~ring_sel;
            modem_chg = lfsr[11];
            audio_en  = lfsr[12];
            spk_in    = lfsr[5];
            step(1);
        end
        finish_run();
    end

endmodule